// File: doc/BRIEF.md
# Sigma-delta bitstream receiver

This block is the serial front end for an external sigma-delta modulator or a PDM microphone. It picks one of eight serial input pin pairs and brings the selected one-bit stream into the system clock domain. It then recovers one data bit per modulator clock and hands each bit to a downstream decimation stage as a one-cycle strobe with the bit value.

Two capture styles are supported. In the clocked (SPI-style) styles, a clock line paces the data. That clock can come from the channel's own clock pin, from an internally generated clock that the block also drives out to the modulator, or from that internal clock halved. The data is taken on the rising or on the falling edge of the chosen clock. In the self-clocked styles, the data line carries Manchester code. The bit timing is recovered from the data transitions using a programmed nominal bit period, and either transition polarity can be made to mean one. A watchdog counter flags a channel whose clock or data has gone quiet. An alternate routing option lets channel n read its data from pin n+1, so two modulators can share one clock pin.

Configuration (mode, clock source, channel, routing) is changed only while `enable` is low. Raising `enable` restarts the decoder phase and the quiet-line counter.

Top module: `sdm_bitstream_rx`

## Requirements
- R1: With `mode`=0, a data bit is taken on every rising edge of the selected clock, and the bit value is the data pin level seen together with that edge.
- R2: With `mode`=1, a data bit is taken on every falling edge of the selected clock instead, and rising edges produce no bit.
- R3: With `mode`=2 (Manchester), an accepted rising data transition yields bit 0 and an accepted falling transition yields bit 1; the clock pins are not used.
- R4: With `mode`=3 (Manchester, inverted polarity), an accepted rising transition yields bit 1 and an accepted falling transition yields bit 0.
- R5: In the Manchester modes, the first transition after enable is accepted. After that, a transition is accepted only if at least floor(3*`bit_period`/4) system cycles have passed since the last accepted one; earlier transitions, such as bit-boundary edges, are ignored.
- R6: With `clk_src`=0, the clock is the channel's own pin `ser_clk[chan_sel]`; every other clock pin and every unselected data pin has no effect on the output.
- R7: With `clk_src`=1, the clock is `sclk_out`. While enabled, `sclk_out` toggles every `clk_div`+1 system cycles; while disabled, it is held low.
- R8: With `clk_src`=3, the clock is a half-rate clock that toggles at each low-to-high step of `sclk_out` (low while disabled). With `clk_src`=2, the clock is that half-rate clock inverted, so the mode-0 capture lands on its falling edge.
- R9: With `alt_route`=0, the data pin is `chan_sel`; with `alt_route`=1, it is (`chan_sel`+1) mod 8, wrapping from 7 to 0. The clock pin stays at `chan_sel` in both cases.
- R10: `clk_absent` is high while enabled once `absence_limit` or more system cycles have passed since the last capture edge (clocked modes) or data transition (Manchester modes). Any such activity clears it on the next cycle.
- R11: While `enable` is low, `bit_valid` and `clk_absent` stay low whatever the pins do. Enabling again restarts the Manchester lock from the first transition.
- R12: Each input pin passes through a two-flop synchroniser. A pin change first sampled at system edge j produces its strobe for exactly one cycle after edge j+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run; configuration is changed only while low |
| mode | input | 2 | 0 clocked rising, 1 clocked falling, 2 Manchester rise=0, 3 Manchester rise=1 |
| clk_src | input | 2 | 0 channel clock pin, 1 internal clock, 2 inverted half-rate clock, 3 half-rate clock |
| chan_sel | input | 3 | Selected serial channel |
| alt_route | input | 1 | Take data from the next pin up |
| clk_div | input | 8 | Internal clock half period minus one, in system cycles |
| bit_period | input | 8 | Nominal Manchester bit period in system cycles |
| absence_limit | input | 16 | Quiet cycles before the absence flag is raised |
| ser_clk | input | 8 | Serial clock pins |
| ser_dat | input | 8 | Serial data pins |
| sclk_out | output | 1 | Generated serial clock to the modulator |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| bit_data | output | 1 | Recovered bit, valid with the strobe |
| clk_absent | output | 1 | Clock or data activity missing |

## Verification
The bench sends Manchester streams that contain runs of equal bits. Those runs put extra boundary transitions half a period after each mid-bit edge, so a decoder with a wrong acceptance window or wrong polarity would emit extra or flipped bits and the bit queue would disagree. Clocked streams are sent with the edge choice switched and with noise on every unselected pin. A design that sampled the wrong edge, read the wrong pin, or mishandled the 7-to-0 wrap of alternate routing would therefore strobe at the wrong cycle or return the wrong value. The internal and halved clock sources are compared against the block's own generated clock: a halving stage keyed to the wrong edge shifts every capture by half a period. Disabling the channel while the pins keep toggling exposes any strobe that leaks through. Quiet spells longer than the limit show whether the absence flag rises and falls at the right cycle.

// File: rtl/sdm_rx_pkg.sv
package sdm_rx_pkg;

  typedef enum logic [1:0] {
    CH_SPI_RISE = 2'd0,
    CH_SPI_FALL = 2'd1,
    CH_MAN_R0   = 2'd2,
    CH_MAN_R1   = 2'd3
  } ch_mode_e;

  typedef enum logic [1:0] {
    CK_PIN       = 2'd0,
    CK_INT       = 2'd1,
    CK_HALF_INV  = 2'd2,
    CK_HALF      = 2'd3
  } ck_src_e;

  // Earliest distance, in system cycles, between two accepted mid-bit edges.
  function automatic int unsigned manch_window(input int unsigned period);
    return (3 * period) / 4;
  endfunction

  // Pin that feeds the data path of a channel.
  function automatic int unsigned data_pin(input int unsigned chan, input logic alt,
                                           input int unsigned n);
    return alt ? ((chan + 1) % n) : chan;
  endfunction

endpackage

// File: rtl/sdm_clkgen.sv
module sdm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  output logic             sclk_o,
  output logic             half_o
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt    <= '0;
      sclk_o <= 1'b0;
      half_o <= 1'b0;
    end else if (cnt == div) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
      if (!sclk_o) half_o <= ~half_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdm_pin_sel.sv
module sdm_pin_sel
  import sdm_rx_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int SYNC_N = 2,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ser_clk,
  input  logic [NCH-1:0]   ser_dat,
  input  logic [SEL_W-1:0] clk_idx,
  input  logic [SEL_W-1:0] dat_idx,
  input  ck_src_e          src,
  input  logic             int_clk,
  input  logic             half_clk,
  output logic             c_now,
  output logic             c_prev,
  output logic             d_now,
  output logic             d_prev
);

  logic raw_clk;
  logic raw_dat;
  logic [SYNC_N:0] c_pipe;
  logic [SYNC_N:0] d_pipe;

  always_comb begin
    unique case (src)
      CK_PIN:      raw_clk = ser_clk[clk_idx];
      CK_INT:      raw_clk = int_clk;
      CK_HALF_INV: raw_clk = ~half_clk;
      default:     raw_clk = half_clk;
    endcase
  end

  assign raw_dat = ser_dat[dat_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_pipe <= '0;
      d_pipe <= '0;
    end else begin
      c_pipe <= {c_pipe[SYNC_N-1:0], raw_clk};
      d_pipe <= {d_pipe[SYNC_N-1:0], raw_dat};
    end
  end

  assign c_now  = c_pipe[SYNC_N-1];
  assign c_prev = c_pipe[SYNC_N];
  assign d_now  = d_pipe[SYNC_N-1];
  assign d_prev = d_pipe[SYNC_N];

endmodule

// File: rtl/sdm_manch_dec.sv
module sdm_manch_dec
  import sdm_rx_pkg::*;
#(
  parameter int PER_W = 8,
  localparam int CNT_W = PER_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trans,
  input  logic             level,
  input  logic             rise_is_one,
  input  logic [PER_W-1:0] period,
  output logic             accept,
  output logic             bit_o
);

  logic [CNT_W-1:0] since;
  logic [CNT_W-1:0] win;
  logic             locked;

  assign win    = CNT_W'(manch_window(32'(period)));
  assign accept = enable && trans && (!locked || since >= win);
  assign bit_o  = rise_is_one ? level : ~level;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      since  <= '0;
      locked <= 1'b0;
    end else if (accept) begin
      since  <= CNT_W'(1);
      locked <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

endmodule

// File: rtl/sdm_absence.sv
module sdm_absence #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              act,
  input  logic [IDLE_W-1:0] limit,
  output logic              absent
);

  logic [IDLE_W-1:0] idle;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= enable;
      if (!enable || act)  idle <= '0;
      else if (idle != '1) idle <= idle + 1'b1;
    end
  end

  assign absent = en_q && (idle >= limit);

endmodule

// File: rtl/sdm_bitstream_rx.sv
module sdm_bitstream_rx
  import sdm_rx_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DIV_W  = 8,
  parameter int PER_W  = 8,
  parameter int IDLE_W = 16,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [1:0]        clk_src,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic              alt_route,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [PER_W-1:0]  bit_period,
  input  logic [IDLE_W-1:0] absence_limit,
  input  logic [NCH-1:0]    ser_clk,
  input  logic [NCH-1:0]    ser_dat,
  output logic              sclk_out,
  output logic              bit_valid,
  output logic              bit_data,
  output logic              clk_absent
);

  ch_mode_e         mode_e;
  logic             is_man;
  logic [SEL_W-1:0] dat_idx;
  logic             half_clk;
  logic             c_now, c_prev, d_now, d_prev;
  logic             smp_evt;     // capture edge of the clocked styles
  logic             trans_evt;   // any data transition
  logic             man_accept;  // transition taken as mid-bit
  logic             man_bit;
  logic             act_evt;     // activity seen by the absence counter

  assign mode_e  = ch_mode_e'(mode);
  assign is_man  = mode_e == CH_MAN_R0 || mode_e == CH_MAN_R1;
  assign dat_idx = SEL_W'(data_pin(32'(chan_sel), alt_route, NCH));

  sdm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .div    (clk_div),
    .sclk_o (sclk_out),
    .half_o (half_clk)
  );

  sdm_pin_sel #(.NCH(NCH), .SYNC_N(2)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .clk_idx  (chan_sel),
    .dat_idx  (dat_idx),
    .src      (ck_src_e'(clk_src)),
    .int_clk  (sclk_out),
    .half_clk (half_clk),
    .c_now    (c_now),
    .c_prev   (c_prev),
    .d_now    (d_now),
    .d_prev   (d_prev)
  );

  assign smp_evt   = (mode_e == CH_SPI_FALL) ? (c_prev & ~c_now) : (c_now & ~c_prev);
  assign trans_evt = d_now ^ d_prev;

  sdm_manch_dec #(.PER_W(PER_W)) u_manch (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable && is_man),
    .trans       (trans_evt),
    .level       (d_now),
    .rise_is_one (mode_e == CH_MAN_R1),
    .period      (bit_period),
    .accept      (man_accept),
    .bit_o       (man_bit)
  );

  assign act_evt = is_man ? trans_evt : smp_evt;

  sdm_absence #(.IDLE_W(IDLE_W)) u_absence (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .act    (act_evt),
    .limit  (absence_limit),
    .absent (clk_absent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= is_man ? man_accept : smp_evt;
      bit_data  <= is_man ? man_bit : d_now;
    end
  end

endmodule

module sdm_bitstream_rx_chk #(
  parameter int PER_W  = 8,
  parameter int IDLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [1:0]        mode,
  input logic [PER_W-1:0]  bit_period,
  input logic [IDLE_W-1:0] absence_limit,
  input logic              smp_evt,
  input logic              man_accept,
  input logic              act_evt,
  input logic              sclk_out,
  input logic              bit_valid,
  input logic              clk_absent
);

  p_spi_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !mode[1] && smp_evt) |=> bit_valid);

  p_man_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode[1] && man_accept) |=> bit_valid);

  p_sclk_low_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sclk_out);

  p_activity_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_evt && absence_limit != '0) |=> !clk_absent);

  p_valid_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(enable));

  p_absent_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_absent |-> $past(enable));

  p_single_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && (!mode[1] || bit_period >= PER_W'(4))) |=> !bit_valid);

endmodule

bind sdm_bitstream_rx sdm_bitstream_rx_chk #(.PER_W(PER_W), .IDLE_W(IDLE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .mode          (mode),
  .bit_period    (bit_period),
  .absence_limit (absence_limit),
  .smp_evt       (smp_evt),
  .man_accept    (man_accept),
  .act_evt       (act_evt),
  .sclk_out      (sclk_out),
  .bit_valid     (bit_valid),
  .clk_absent    (clk_absent)
);

// File: tb/sdm_bitstream_rx_tb.sv
module sdm_bitstream_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  clk_src = 2'd0;
  logic [2:0]  chan_sel = 3'd0;
  logic        alt_route = 1'b0;
  logic [7:0]  clk_div = 8'd3;
  logic [7:0]  bit_period = 8'd16;
  logic [15:0] absence_limit = 16'd40;
  logic [7:0]  ser_clk = 8'h00;
  logic [7:0]  ser_dat = 8'h00;
  logic        sclk_out, bit_valid, bit_data, clk_absent;

  always #5 clk = ~clk;

  sdm_bitstream_rx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .clk_src(clk_src),
    .chan_sel(chan_sel), .alt_route(alt_route), .clk_div(clk_div),
    .bit_period(bit_period), .absence_limit(absence_limit),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .sclk_out(sclk_out),
    .bit_valid(bit_valid), .bit_data(bit_data), .clk_absent(clk_absent)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  int    rx_cnt = 0;
  string tag = "R11";
  bit    man_chk = 1'b0;
  bit    sent_q[$];
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  // ---------------- reference model, evaluated between edges ----------------
  bit         pch[4];
  bit         pdh[4];
  bit         en_n = 1'b0, en_k;
  logic [1:0] mode_n = 2'd0, mode_k;
  bit         locked = 1'b0, hclk = 1'b0, o_prev = 1'b0, have_tog = 1'b0;
  int         last_acc = 0, idle = 0, last_tog = 0;

  always @(negedge clk) begin
    bit exp_v, exp_d, act, nc, nd;
    int di, win;
    cyc++;
    en_k   = en_n;
    mode_k = mode_n;
    exp_v  = 1'b0;
    exp_d  = 1'b0;
    act    = 1'b0;
    win    = (3 * int'(bit_period)) / 4;
    if (!en_k) begin
      locked = 1'b0;
      idle   = 0;
    end else begin
      if (mode_k == 2'd0) begin
        exp_v = pch[2] && !pch[3];
        exp_d = pdh[2];
        act   = exp_v;
      end else if (mode_k == 2'd1) begin
        exp_v = !pch[2] && pch[3];
        exp_d = pdh[2];
        act   = exp_v;
      end else begin
        act   = pdh[2] != pdh[3];
        exp_v = act && (!locked || (cyc - last_acc) >= win);
        exp_d = (mode_k == 2'd3) ? pdh[2] : !pdh[2];
        if (exp_v) begin
          locked   = 1'b1;
          last_acc = cyc;
        end
      end
      if (act) idle = 0;
      else if (idle < 65535) idle++;
    end
    chk(bit_valid == exp_v, tag, "bit_valid", int'(bit_valid), int'(exp_v));
    if (exp_v && bit_valid) chk(bit_data == exp_d, tag, "bit_data", int'(bit_data), int'(exp_d));
    chk(clk_absent == (en_k && idle >= int'(absence_limit)), "R10", "clk_absent",
        int'(clk_absent), int'(en_k && idle >= int'(absence_limit)));
    if (bit_valid) begin
      rx_cnt++;
      if (man_chk) begin
        if (sent_q.size() == 0) chk(1'b0, tag, "unexpected Manchester bit", 1, 0);
        else begin
          bit e;
          e = sent_q.pop_front();
          chk(bit_data == e, tag, "decoded bit vs sent", int'(bit_data), int'(e));
        end
      end
    end
    // generated clock behaviour (R7) and the halved clock seen by the bench (R8)
    if (!en_k) begin
      chk(sclk_out == 1'b0, "R7", "sclk_out while disabled", int'(sclk_out), 0);
      have_tog = 1'b0;
      hclk     = 1'b0;
    end else begin
      if (sclk_out != o_prev) begin
        if (have_tog) chk((cyc - last_tog) == int'(clk_div) + 1, "R7", "sclk_out half period",
                          cyc - last_tog, int'(clk_div) + 1);
        have_tog = 1'b1;
        last_tog = cyc;
      end
      if (!o_prev && sclk_out) hclk = !hclk;
    end
    o_prev = sclk_out;
    // pin values the design samples at the coming edge
    case (clk_src)
      2'd0:    nc = ser_clk[chan_sel];
      2'd1:    nc = sclk_out;
      2'd2:    nc = !hclk;
      default: nc = hclk;
    endcase
    di = alt_route ? (int'(chan_sel) + 1) % 8 : int'(chan_sel);
    nd = ser_dat[di];
    for (int i = 3; i > 0; i--) begin
      pch[i] = pch[i-1];
      pdh[i] = pdh[i-1];
    end
    pch[0] = nc;
    pdh[0] = nd;
    en_n   = enable && rst_n;
    mode_n = mode;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int dpin();
    return alt_route ? (int'(chan_sel) + 1) % 8 : int'(chan_sel);
  endfunction

  task automatic drive(input bit cv, input bit dv);
    ser_clk = 8'($urandom);
    ser_dat = 8'($urandom);
    ser_clk[chan_sel] = cv;
    ser_dat[dpin()]   = dv;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] s, input logic [2:0] ch,
                     input bit alt, input bit lvl);
    tick();
    enable = 1'b0;
    repeat (3) tick();
    mode = m; clk_src = s; chan_sel = ch; alt_route = alt;
    ser_clk = 8'h00;
    ser_dat = 8'h00;
    ser_dat[dpin()] = lvl;
    repeat (5) tick();
    enable = 1'b1;
  endtask

  task automatic spi_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = 1'($urandom);
      repeat (4) begin tick(); drive(1'b0, b); end
      repeat (4) begin tick(); drive(1'b1, b); end
    end
    repeat (6) begin tick(); drive(1'b0, 1'b0); end
  endtask

  task automatic quiet(input int n);
    bit cv, dv;
    cv = ser_clk[chan_sel];
    dv = ser_dat[dpin()];
    repeat (n) begin tick(); drive(cv, dv); end
  endtask

  task automatic free_run(input int n);
    repeat (n) begin
      tick();
      ser_clk = 8'($urandom);
      ser_dat = 8'($urandom);
    end
  endtask

  // first-half line level of a Manchester bit
  function automatic bit first_half(input bit b);
    return (mode == 2'd2) ? b : !b;
  endfunction

  task automatic man_run(input bit bits[$]);
    int hp;
    hp = int'(bit_period) / 2;
    repeat (10) begin tick(); drive(1'b0, first_half(bits[0])); end
    foreach (bits[i]) begin
      sent_q.push_back(bits[i]);
      repeat (hp) begin tick(); drive(1'(i), first_half(bits[i])); end
      repeat (hp) begin tick(); drive(1'(i + 1), !first_half(bits[i])); end
    end
  endtask

  initial begin
    int rx0;
    bit pat_a[$] = '{0, 0, 1, 1, 1, 0, 1, 0, 0, 1, 1, 0, 0, 0, 1, 1};
    bit pat_b[$] = '{1, 1, 0, 1, 0, 0, 0, 1, 1, 0, 1, 1};
    repeat (4) tick();
    chk(bit_valid == 1'b0, "R11", "bit_valid in reset", int'(bit_valid), 0);
    chk(clk_absent == 1'b0, "R11", "clk_absent in reset", int'(clk_absent), 0);
    chk(sclk_out == 1'b0, "R7", "sclk_out in reset", int'(sclk_out), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // clocked capture on the rising edge from the channel's own pin
    tag = "R1";
    cfg(2'd0, 2'd0, 3'd2, 1'b0, 1'b0);
    rx0 = rx_cnt;
    spi_run(20);
    chk(rx_cnt - rx0 == 20, "R6", "bits from pin clock", rx_cnt - rx0, 20);
    quiet(50);
    chk(clk_absent == 1'b1, "R10", "flag after quiet clocked line", int'(clk_absent), 1);

    tag = "R12";
    cfg(2'd0, 2'd0, 3'd0, 1'b0, 1'b0);
    spi_run(8);

    // falling-edge capture
    tag = "R2";
    cfg(2'd1, 2'd0, 3'd5, 1'b0, 1'b0);
    rx0 = rx_cnt;
    spi_run(20);
    chk(rx_cnt - rx0 == 20, "R2", "bits on falling edges", rx_cnt - rx0, 20);

    // internal clock
    tag = "R7";
    cfg(2'd0, 2'd1, 3'd1, 1'b0, 1'b0);
    rx0 = rx_cnt;
    free_run(200);
    chk(rx_cnt - rx0 >= 20, "R7", "bits on internal clock", rx_cnt - rx0, 20);

    // halved internal clock, both edges
    tag = "R8";
    cfg(2'd0, 2'd2, 3'd4, 1'b0, 1'b0);
    rx0 = rx_cnt;
    free_run(300);
    chk(rx_cnt - rx0 >= 15, "R8", "bits on inverted half clock", rx_cnt - rx0, 15);
    cfg(2'd1, 2'd3, 3'd4, 1'b0, 1'b0);
    rx0 = rx_cnt;
    free_run(300);
    chk(rx_cnt - rx0 >= 15, "R8", "bits on half clock", rx_cnt - rx0, 15);

    // alternate routing, including wrap from 7 to 0
    tag = "R9";
    cfg(2'd0, 2'd0, 3'd7, 1'b1, 1'b0);
    rx0 = rx_cnt;
    spi_run(16);
    chk(rx_cnt - rx0 == 16, "R9", "bits with wrapped routing", rx_cnt - rx0, 16);
    cfg(2'd1, 2'd0, 3'd3, 1'b1, 1'b0);
    spi_run(16);

    // Manchester, rising means 0
    tag = "R3";
    man_chk = 1'b1;
    bit_period = 8'd16;
    cfg(2'd2, 2'd0, 3'd6, 1'b0, pat_a[0]);
    rx0 = rx_cnt;
    man_run(pat_a);
    quiet(8);
    chk(rx_cnt - rx0 == pat_a.size(), "R3", "Manchester bit count", rx_cnt - rx0, pat_a.size());
    chk(sent_q.size() == 0, "R5", "boundary edges ignored", sent_q.size(), 0);
    quiet(50);
    chk(clk_absent == 1'b1, "R10", "flag after quiet data line", int'(clk_absent), 1);

    // Manchester, rising means 1, shorter period
    tag = "R4";
    bit_period = 8'd12;
    cfg(2'd3, 2'd0, 3'd1, 1'b0, !pat_b[0]);
    rx0 = rx_cnt;
    man_run(pat_b);
    quiet(6);
    chk(rx_cnt - rx0 == pat_b.size(), "R4", "inverted Manchester count", rx_cnt - rx0, pat_b.size());
    chk(sent_q.size() == 0, "R5", "window with period 12", sent_q.size(), 0);

    // disabled channel ignores activity; re-enable relocks
    tag = "R11";
    man_chk = 1'b0;
    tick();
    enable = 1'b0;
    rx0 = rx_cnt;
    for (int i = 0; i < 60; i++) begin
      tick();
      drive(1'(i / 3), 1'(i / 4));
    end
    chk(rx_cnt == rx0, "R11", "bits while disabled", rx_cnt - rx0, 0);
    chk(clk_absent == 1'b0, "R11", "flag while disabled", int'(clk_absent), 0);
    man_chk = 1'b1;
    cfg(2'd3, 2'd0, 3'd1, 1'b0, !pat_a[0]);
    rx0 = rx_cnt;
    man_run(pat_a);
    quiet(6);
    chk(rx_cnt - rx0 == pat_a.size(), "R11", "relock after enable", rx_cnt - rx0, pat_a.size());
    man_chk = 1'b0;

    repeat (4) tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule